// File: doc/BRIEF.md
# Interrupt Pending Priority Selector

This block decides, once per clock, whether a hart should take an interrupt now and which cause number it should report. It looks at the pending and enable vectors, the delegation mask, the current privilege level and the global enable bits. A bit becomes a candidate when it is both pending and enabled. Each candidate is then gated by the eligibility of the privilege level that owns it: machine level if the bit is not delegated, supervisor level if it is. The lowest-numbered surviving bit wins.

When virtualization is active, selection runs in two tiers. Bits outside the virtual-supervisor group (bits 2, 6 and 10) are tried first. They are gated only by hypervisor-supervisor eligibility, and a win in this tier also raises a flag that forces the trap to the hypervisor. Only when that tier is empty are the virtual-supervisor bits used as the candidate set, with the normal delegation gating. When virtualization is off, the virtual-supervisor bits are never selected. The decision is registered, so it appears at the outputs one clock after the inputs are sampled.

Top module: `irq_prio_sel`

## Requirements
- R1: A synchronous active-high reset drives take_o, force_hs_o and cause_o to 0.
- R2: A bit is a candidate only when both its pending bit and its enable bit are 1. The decision for inputs sampled at one rising edge appears at the outputs after that edge.
- R3: A non-delegated candidate (delegation bit 0) is eligible when privilege is U or S, or when privilege is M (priv_i=3) with m_gie_i=1.
- R4: A delegated candidate (delegation bit 1) is eligible when privilege is U, or when privilege is S (priv_i=1) with s_gie_i=1. It is never eligible at M.
- R5: Among eligible candidates, cause_o is the lowest bit index and take_o is 1.
- R6: With no eligible candidate, take_o is 0 and cause_o is 0.
- R7: With virt_i=0, the bits at indices 2, 6 and 10 are never selected, whatever their pending, enable and delegation bits are.
- R8: With virt_i=1, candidates outside bits 2, 6 and 10 are eligible when privilege is U, or S with hs_gie_i=1, and delegation does not affect them. If any is eligible, the lowest one is selected and force_hs_o is 1.
- R9: With virt_i=1 and no eligible candidate under R8, only bits 2, 6 and 10 are considered, gated as in R3 and R4, and force_hs_o is 0.
- R10: A priv_i value of 2 behaves exactly as U (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pend_i | input | 16 | Pending interrupt bits |
| irq_en_i | input | 16 | Per-bit interrupt enables |
| irq_deleg_i | input | 16 | Delegation to supervisor, one bit per cause |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M, 2 acts as U |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| hs_gie_i | input | 1 | Hypervisor-supervisor global interrupt enable |
| virt_i | input | 1 | Virtualization active |
| take_o | output | 1 | Interrupt to be taken (registered) |
| cause_o | output | 4 | Selected cause index (registered) |
| force_hs_o | output | 1 | Selected cause must trap to the hypervisor (registered) |

## Verification
The hypervisor-tier selection and the virtual-supervisor selection can both have candidates in the same cycle. The bench provokes this by raising bit 1 or bit 9 together with bit 2 while virt_i is set, and by switching hs_gie_i and the privilege so that the hypervisor tier is either eligible or empty. The delegated and non-delegated paths can also both be eligible at once. The bench checks that the lowest index wins across both. A behavioural reference model predicts take, cause and the force flag on every clock, and the outputs are judged against it for directed and random inputs.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_R = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    // Indices of the virtual-supervisor soft, timer and external bits
    localparam logic [63:0] VS_BITS = 64'h0000_0000_0000_0444;

    // The reserved encoding behaves as user level
    function automatic priv_e norm_priv(input logic [1:0] raw);
        return (raw == 2'd2) ? PRIV_U : priv_e'(raw);
    endfunction
endpackage

// File: rtl/irq_elig.sv
module irq_elig
    import irq_sel_pkg::*;
#(
    parameter priv_e LEVEL = PRIV_M
) (
    input  priv_e priv_i,
    input  logic  gie_i,
    output logic  ok_o
);
    always_comb begin
        ok_o = (priv_i < LEVEL) || ((priv_i == LEVEL) && gie_i);
    end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int N = 16
) (
    input  logic [N-1:0] cand_i,
    input  logic [N-1:0] deleg_i,
    input  logic         m_ok_i,
    input  logic         s_ok_i,
    output logic [N-1:0] gated_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign gated_o[i] = cand_i[i] & (deleg_i[i] ? s_ok_i : m_ok_i);
    end
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
    parameter int N = 16,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] vec_i,
    output logic         hit_o,
    output logic [W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = W'(i);
        end
        hit_o = |vec_i;
    end

    always_comb begin
        if (hit_o) begin
            assert_lowest_first_R5: assert (vec_i[idx_o] &&
                ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_sel_pkg::*;
#(
    parameter int N = 16,
    localparam int CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_pend_i,
    input  logic [N-1:0]  irq_en_i,
    input  logic [N-1:0]  irq_deleg_i,
    input  logic [1:0]    priv_i,
    input  logic          m_gie_i,
    input  logic          s_gie_i,
    input  logic          hs_gie_i,
    input  logic          virt_i,
    output logic          take_o,
    output logic [CW-1:0] cause_o,
    output logic          force_hs_o
);
    localparam logic [N-1:0] VS_MASK = N'(VS_BITS);

    priv_e         priv_n;
    logic          m_ok, s_ok, hs_ok;
    logic [N-1:0]  cand, hs_cand, base, gated;
    logic          hs_hit, main_hit;
    logic [CW-1:0] hs_idx, main_idx;
    logic          take_q, force_q;
    logic [CW-1:0] cause_q;

    assign priv_n  = norm_priv(priv_i);
    assign cand    = irq_pend_i & irq_en_i;
    assign hs_cand = cand & ~VS_MASK & {N{hs_ok & virt_i}};
    assign base    = virt_i ? (cand & VS_MASK) : (cand & ~VS_MASK);

    irq_elig #(.LEVEL(PRIV_M)) u_m_elig  (.priv_i(priv_n), .gie_i(m_gie_i),  .ok_o(m_ok));
    irq_elig #(.LEVEL(PRIV_S)) u_s_elig  (.priv_i(priv_n), .gie_i(s_gie_i),  .ok_o(s_ok));
    irq_elig #(.LEVEL(PRIV_S)) u_hs_elig (.priv_i(priv_n), .gie_i(hs_gie_i), .ok_o(hs_ok));

    irq_route #(.N(N)) u_route (
        .cand_i(base), .deleg_i(irq_deleg_i),
        .m_ok_i(m_ok), .s_ok_i(s_ok), .gated_o(gated)
    );

    irq_lowest #(.N(N)) u_hs_pick   (.vec_i(hs_cand), .hit_o(hs_hit),   .idx_o(hs_idx));
    irq_lowest #(.N(N)) u_main_pick (.vec_i(gated),   .hit_o(main_hit), .idx_o(main_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q  <= 1'b0;
            force_q <= 1'b0;
            cause_q <= '0;
        end else if (hs_hit) begin
            take_q  <= 1'b1;
            force_q <= 1'b1;
            cause_q <= hs_idx;
        end else begin
            take_q  <= main_hit;
            force_q <= 1'b0;
            cause_q <= main_hit ? main_idx : '0;
        end
    end

    assign take_o     = take_q;
    assign cause_o    = cause_q;
    assign force_hs_o = force_q;

    assert_cand_source_R2: assert property (@(posedge clk) disable iff (rst)
        take_q |-> ((($past(irq_pend_i & irq_en_i) >> cause_q) & N'(1)) != '0));

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !take_q |-> (cause_q == '0 && !force_q));

    assert_m_masked_R3: assert property (@(posedge clk) disable iff (rst)
        (priv_i == 2'd3 && !m_gie_i) |=> !take_q);

    assert_vs_needs_virt_R7: assert property (@(posedge clk) disable iff (rst)
        (take_q && ((VS_MASK >> cause_q) & N'(1)) != '0) |-> $past(virt_i));

    assert_force_virt_R8: assert property (@(posedge clk) disable iff (rst)
        force_q |-> (take_q && $past(virt_i)));
endmodule

// File: tb/irq_prio_sel_tb.sv
module irq_prio_sel_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pend = '0, en = '0, del = '0;
    logic [1:0]  priv = '0;
    logic        mg = 1'b0, sg = 1'b0, hg = 1'b0, virt = 1'b0;
    logic        take, force_hs;
    logic [3:0]  cause;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_sel u_dut (
        .clk(clk), .rst(rst), .irq_pend_i(pend), .irq_en_i(en),
        .irq_deleg_i(del), .priv_i(priv), .m_gie_i(mg), .s_gie_i(sg),
        .hs_gie_i(hg), .virt_i(virt), .take_o(take), .cause_o(cause),
        .force_hs_o(force_hs)
    );

    // Behavioural model of the selection rules
    task automatic model(output bit e_take, output int e_cause, output bit e_force);
        int p;
        bit m_ok, s_ok, h_ok, is_vs, ok;
        p = (priv == 2'd2) ? 0 : int'(priv);
        m_ok = (p < 3) || mg;
        s_ok = (p == 0) || (p == 1 && sg);
        h_ok = (p == 0) || (p == 1 && hg);
        e_take = 0; e_cause = 0; e_force = 0;
        if (virt && h_ok) begin
            for (int i = 0; i < 16; i++) begin
                is_vs = (i == 2 || i == 6 || i == 10);
                if (!e_take && pend[i] && en[i] && !is_vs) begin
                    e_take = 1; e_cause = i; e_force = 1;
                end
            end
        end
        if (!e_take) begin
            for (int i = 0; i < 16; i++) begin
                is_vs = (i == 2 || i == 6 || i == 10);
                ok = del[i] ? s_ok : m_ok;
                if (!e_take && pend[i] && en[i] && (virt ? is_vs : !is_vs) && ok) begin
                    e_take = 1; e_cause = i;
                end
            end
        end
    endtask

    task automatic compare(input bit e_take, input int e_cause, input bit e_force, input string tag);
        tests++;
        if (take !== e_take || int'(cause) != e_cause || force_hs !== e_force) begin
            fails++;
            $display("FAIL %s: got take=%0b cause=%0d force=%0b expected take=%0b cause=%0d force=%0b",
                     tag, take, cause, force_hs, e_take, e_cause, e_force);
        end
    endtask

    task automatic step(input logic [15:0] p_, input logic [15:0] e_, input logic [15:0] d_,
                        input logic [1:0] pr, input bit m_, input bit s_, input bit h_,
                        input bit v_, input string tag);
        bit et, ef;
        int ec;
        pend = p_; en = e_; del = d_; priv = pr; mg = m_; sg = s_; hg = h_; virt = v_;
        model(et, ec, ef);
        @(negedge clk);
        compare(et, ec, ef, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        pend = '1; en = '1; mg = 1; sg = 1; hg = 1;
        repeat (3) @(negedge clk);
        compare(0, 0, 0, "R1 reset");
        rst = 1'b0;
        // R2 candidate = pending AND enable
        step(16'h0880, 16'hFFFF, 16'h0, 2'd0, 0, 0, 0, 0, "R2 both enabled");
        step(16'h0880, 16'h0800, 16'h0, 2'd0, 0, 0, 0, 0, "R2 enable mask");
        // R3 machine eligibility
        step(16'h0080, 16'hFFFF, 16'h0, 2'd3, 0, 1, 1, 0, "R3 M masked");
        step(16'h0080, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0, 0, "R3 M enabled");
        step(16'h0080, 16'hFFFF, 16'h0, 2'd1, 0, 0, 0, 0, "R3 below M");
        // R4 supervisor eligibility for delegated bits
        step(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 0, 0, "R4 S masked");
        step(16'h0020, 16'hFFFF, 16'h0020, 2'd1, 0, 1, 0, 0, "R4 S enabled");
        step(16'h0020, 16'hFFFF, 16'h0020, 2'd3, 1, 1, 0, 0, "R4 never at M");
        step(16'h0020, 16'hFFFF, 16'h0020, 2'd0, 0, 0, 0, 0, "R4 from U");
        // R5 lowest index across both paths
        step(16'h8030, 16'hFFFF, 16'h0010, 2'd0, 0, 0, 0, 0, "R5 lowest wins");
        step(16'h8030, 16'hFFFF, 16'h0010, 2'd1, 0, 0, 0, 0, "R5 delegated masked");
        // R6 nothing pending
        step(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1, 1, 1, 0, "R6 idle");
        // R7 VS bits ignored when not virtualized
        step(16'h0444, 16'hFFFF, 16'h0444, 2'd0, 1, 1, 1, 0, "R7 vs ignored");
        step(16'h0544, 16'hFFFF, 16'h0, 2'd0, 1, 1, 1, 0, "R7 next non-vs");
        // R8 hypervisor tier first, delegation ignored, force set
        step(16'h0206, 16'hFFFF, 16'h0202, 2'd1, 0, 0, 1, 1, "R8 hs tier wins");
        step(16'h0204, 16'hFFFF, 16'h0200, 2'd0, 0, 0, 0, 1, "R8 from U");
        // R9 fall back to VS bits
        step(16'h0204, 16'hFFFF, 16'h0004, 2'd1, 0, 1, 0, 1, "R9 vs selected");
        step(16'h0204, 16'hFFFF, 16'h0004, 2'd1, 0, 0, 0, 1, "R9 vs masked");
        step(16'h0440, 16'hFFFF, 16'h0000, 2'd1, 0, 0, 0, 1, "R9 vs non-deleg");
        // R10 encoding 2 acts as U
        step(16'h0008, 16'hFFFF, 16'h0, 2'd2, 0, 0, 0, 0, "R10 M path as U");
        step(16'h0002, 16'hFFFF, 16'h0002, 2'd2, 0, 0, 0, 0, "R10 S path as U");
        step(16'h0002, 16'hFFFF, 16'h0000, 2'd2, 0, 0, 0, 1, "R10 hs tier as U");
        // Random mix, checked against the model every clock
        for (int k = 0; k < 400; k++) begin
            step(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R5 R9 random");
        end
        rst = 1'b1;
        @(negedge clk);
        compare(0, 0, 0, "R1 reset again");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule